// File: doc/BRIEF.md
# I2C Serial Memory Target Interface

This block is the bus-facing front end of a byte-addressed 32K x 8 nonvolatile memory model. It watches the serial clock and data lines of an I2C bus, recognises START and STOP conditions, shifts bytes in and out, and drives the acknowledge bit. A select byte addresses the device. It carries a fixed type code, three bits that must equal the `strap` pins, and a direction bit. Up to eight such targets can therefore sit on one bus.

A write transaction sends two word-address bytes and then data bytes. The data bytes land in a 64-entry page buffer, at offsets that wrap inside the addressed page. After the STOP, the buffered bytes are handed to the storage back end one per cycle. The block then holds a commit request until the back end reports that its internal write cycle has finished. While that commit is in flight, the target refuses its own select byte, so a controller can poll for completion. Read transactions stream bytes from the back end's combinational read port, starting at the internal address counter. A high `wp` input turns every write into a no-op. The `strap` and `wp` pins are expected to be pulled low on the board when nothing drives them.

Top module: `i2c_mem_target`

## Requirements
- R1: A select byte of the form type code 1010 (bits 7..4), strap copy (bits 3..1), direction (bit 0, 1 = read) is acknowledged only when bits 3..1 equal `strap`. A wrong type code or strap leaves SDA released in the ninth clock.
- R2: After a write select, two address bytes follow, high byte first. Bit 7 of the high byte is ignored, which gives a 15-bit word address.
- R3: Each accepted data byte is stored at the current page offset (address bits 5..0), and the offset then increments. The offset wraps from 63 to 0 without changing the page (address bits 14..6). A later byte at the same offset replaces the earlier one.
- R4: A STOP that follows at least one accepted data byte starts a commit. Every loaded offset is presented exactly once on `wr_en`/`wr_addr`/`wr_data`, in ascending offset order. After that, `commit_req` rises and stays high until a cycle with `commit_done` high, and falls in the next cycle.
- R5: From that STOP until the commit completes, the target does not acknowledge its own select byte. Once the commit is done, the select byte is acknowledged again.
- R6: While `wp` is high, the select byte and both address bytes are acknowledged, but data bytes are not, and no `wr_en` pulse or `commit_req` follows.
- R7: A random read is a write select, two address bytes, a repeated START and a read select. It returns the stored byte at that address.
- R8: During a read the address counter advances by one after every byte sent, and it rolls over from 0x7FFF to 0x0000.
- R9: A read select with no preceding address phase (current-address read) starts at the counter value left by the previous access.
- R10: A controller NACK ends the read. SDA stays released until the next START, and the next transaction is served normally.
- R11: The target changes its SDA drive only while SCL is low.
- R12: After reset, SDA is released, `wr_en` is low and `commit_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl | input | 1 | Bus clock line as seen at the pin |
| sda | input | 1 | Bus data line as seen at the pin |
| strap | input | 3 | Device select strap value |
| wp | input | 1 | Write protect, high blocks all writes |
| rd_data | input | 8 | Read data from the back end for `rd_addr` |
| commit_done | input | 1 | Back end reports the internal write cycle finished |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| rd_addr | output | 15 | Current word address counter |
| wr_en | output | 1 | One buffered byte is presented this cycle |
| wr_addr | output | 15 | Address of the presented byte |
| wr_data | output | 8 | Value of the presented byte |
| commit_req | output | 1 | Page transfer finished, awaiting `commit_done` |

## Verification
The hardest state to reach is the commit window. The select byte has to arrive while the page is still being transferred or while `commit_req` waits for the back end. The bench's back-end model therefore holds `commit_done` off for several hundred cycles. The bench sends a select byte right after the STOP and expects a NACK, then keeps re-sending the select until it is acknowledged. A 65-byte write drives the page offset past its wrap and back onto the first offset, so the overwrite case and a fully loaded page are both observed on the write port.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {PH_IDLE, PH_DEV, PH_AH, PH_AL, PH_WR, PH_RD} phase_e;
  typedef enum logic [1:0] {CM_IDLE, CM_WALK, CM_DRAIN, CM_REQ} commit_e;
  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/i2cm_bus_sync.sv
module i2cm_bus_sync #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC:0] scl_sr, sda_sr;
  logic scl_cur, scl_prv, sda_cur, sda_prv;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sr <= '1;
      sda_sr <= '1;
    end else begin
      scl_sr <= {scl_sr[SYNC-1:0], scl};
      sda_sr <= {sda_sr[SYNC-1:0], sda};
    end
  end

  assign scl_cur   = scl_sr[SYNC-1];
  assign scl_prv   = scl_sr[SYNC];
  assign sda_cur   = sda_sr[SYNC-1];
  assign sda_prv   = sda_sr[SYNC];
  assign sda_q     = sda_cur;
  assign scl_rise  = scl_cur & ~scl_prv;
  assign scl_fall  = ~scl_cur & scl_prv;
  assign start_det = scl_cur & scl_prv & sda_prv & ~sda_cur;
  assign stop_det  = scl_cur & scl_prv & ~sda_prv & sda_cur;
endmodule

// File: rtl/i2cm_page_buf.sv
module i2cm_page_buf
  import i2cm_pkg::*;
#(
  parameter int AW = 15,
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [PW-1:0] widx,
  input  logic [7:0]    wdata,
  input  logic [AW-PW-1:0] wpage,
  input  logic          go,
  input  logic          done,
  output logic          busy,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          req
);
  localparam int DEPTH = 1 << PW;
  localparam int GW    = AW - PW;

  logic [7:0]       mem [DEPTH];
  logic [DEPTH-1:0] valid;
  logic [GW-1:0]    page_q;
  logic [PW-1:0]    idx, iss_idx;
  logic             iss_v;
  logic [7:0]       rd_q;
  commit_e          st;

  // simple dual-port storage: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    rd_q <= mem[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= CM_IDLE;
      valid   <= '0;
      page_q  <= '0;
      idx     <= '0;
      iss_v   <= 1'b0;
      iss_idx <= '0;
    end else begin
      iss_v   <= (st == CM_WALK) && valid[idx];
      iss_idx <= idx;
      if (we) begin
        valid[widx] <= 1'b1;
        page_q      <= wpage;
      end
      case (st)
        CM_IDLE:  if (go) begin st <= CM_WALK; idx <= '0; end
        CM_WALK: begin
          idx <= idx + 1'b1;
          if (&idx) st <= CM_DRAIN;
        end
        CM_DRAIN: st <= CM_REQ;
        CM_REQ: if (done) begin st <= CM_IDLE; valid <= '0; end
        default:  st <= CM_IDLE;
      endcase
    end
  end

  assign wr_en   = iss_v;
  assign wr_addr = {page_q, iss_idx};
  assign wr_data = rd_q;
  assign req     = (st == CM_REQ);
  assign busy    = (st != CM_IDLE);
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
  import i2cm_pkg::*;
#(
  parameter int AW   = 15,
  parameter int PW   = 6,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl,
  input  logic          sda,
  input  logic [2:0]    strap,
  input  logic          wp,
  input  logic [7:0]    rd_data,
  input  logic          commit_done,
  output logic          sda_oe,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          commit_req
);
  logic sda_q, scl_rise, scl_fall, start_det, stop_det;
  logic busy, buf_we, commit_go, byte_fall, sel_match;

  phase_e        phase, nxt;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg, txreg;
  logic [AW-1:0] addr;
  logic          oe_q, got_data;

  i2cm_bus_sync #(.SYNC(SYNC)) u_sync (
    .clk(clk), .rst(rst), .scl(scl), .sda(sda),
    .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign byte_fall = scl_fall && (bitcnt == 4'd8);
  assign sel_match = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == strap) && !busy;
  assign buf_we    = byte_fall && (phase == PH_WR) && !wp;
  assign commit_go = stop_det && got_data;

  i2cm_page_buf #(.AW(AW), .PW(PW)) u_buf (
    .clk(clk), .rst(rst),
    .we(buf_we), .widx(addr[PW-1:0]), .wdata(shreg), .wpage(addr[AW-1:PW]),
    .go(commit_go), .done(commit_done), .busy(busy),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .req(commit_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      nxt      <= PH_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      txreg    <= '0;
      addr     <= '0;
      oe_q     <= 1'b0;
      got_data <= 1'b0;
    end else if (start_det) begin
      phase  <= PH_DEV;
      nxt    <= PH_IDLE;
      bitcnt <= '0;
      oe_q   <= 1'b0;
    end else if (stop_det) begin
      phase    <= PH_IDLE;
      oe_q     <= 1'b0;
      got_data <= 1'b0;
    end else if (scl_rise) begin
      if (bitcnt != 4'd8) begin
        shreg  <= {shreg[6:0], sda_q};
        bitcnt <= bitcnt + 4'd1;
      end else begin
        bitcnt <= '0;
        if (phase == PH_RD) begin
          addr  <= addr + 1'b1;
          phase <= sda_q ? PH_IDLE : PH_RD;
        end else if (phase != PH_IDLE) begin
          phase <= nxt;
        end
      end
    end else if (scl_fall) begin
      case (phase)
        PH_IDLE: oe_q <= 1'b0;
        PH_RD: begin
          if (bitcnt == 4'd0) begin
            txreg <= rd_data;
            oe_q  <= ~rd_data[7];
          end else if (bitcnt != 4'd8) begin
            oe_q <= ~txreg[~bitcnt[2:0]];
          end else begin
            oe_q <= 1'b0;
          end
        end
        default: begin
          if (bitcnt != 4'd8) begin
            oe_q <= 1'b0;
          end else begin
            case (phase)
              PH_DEV: begin
                oe_q <= sel_match;
                nxt  <= !sel_match ? PH_IDLE : (shreg[0] ? PH_RD : PH_AH);
              end
              PH_AH: begin
                oe_q          <= 1'b1;
                addr[AW-1:8]  <= shreg[AW-9:0];
                nxt           <= PH_AL;
              end
              PH_AL: begin
                oe_q       <= 1'b1;
                addr[7:0]  <= shreg;
                nxt        <= PH_WR;
              end
              default: begin
                if (wp) begin
                  oe_q <= 1'b0;
                  nxt  <= PH_IDLE;
                end else begin
                  oe_q           <= 1'b1;
                  addr[PW-1:0]   <= addr[PW-1:0] + 1'b1;
                  got_data       <= 1'b1;
                  nxt            <= PH_WR;
                end
              end
            endcase
          end
        end
      endcase
    end
  end

  assign sda_oe  = oe_q;
  assign rd_addr = addr;
endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk (
  input logic clk,
  input logic rst,
  input logic scl,
  input logic sda_oe,
  input logic wr_en,
  input logic commit_req,
  input logic commit_done
);
  assert_req_hold_R4: assert property (@(posedge clk) disable iff (rst)
    commit_req && !commit_done |=> commit_req);

  assert_req_drop_R4: assert property (@(posedge clk) disable iff (rst)
    commit_req && commit_done |=> !commit_req);

  assert_no_write_in_req_R4: assert property (@(posedge clk) disable iff (rst)
    commit_req |-> !wr_en);

  assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl);
endmodule

bind i2c_mem_target i2cm_chk u_chk (
  .clk(clk), .rst(rst), .scl(scl), .sda_oe(sda_oe),
  .wr_en(wr_en), .commit_req(commit_req), .commit_done(commit_done)
);

// File: tb/sim_i2c_mem_target.sv
module sim_i2c_mem_target;
  localparam int Q   = 5;
  localparam int LAT = 400;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_line;
  logic [2:0]  strap = 3'b101;
  logic        wp = 1'b0;
  logic [7:0]  rd_data = 8'h00;
  logic        commit_done = 1'b0;
  logic        sda_oe, wr_en, commit_req;
  logic [14:0] rd_addr, wr_addr;
  logic [7:0]  wr_data;

  int nchk = 0, nfail = 0, ncommit = 0, viol = 0;
  logic [22:0] exp_q [$];
  logic [7:0]  bmem [int];
  logic [7:0]  refm [int];
  logic [7:0]  wdat [128];

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_mem_target u0 (
    .clk(clk), .rst(rst), .scl(scl), .sda(sda_line), .strap(strap), .wp(wp),
    .rd_data(rd_data), .commit_done(commit_done), .sda_oe(sda_oe),
    .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit_req(commit_req)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 7) ^ (a >> 8) ^ 32'h5A);
  endfunction

  function automatic logic [7:0] ref_b(int a);
    if (refm.exists(a)) return refm[a];
    return pat(a);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // storage back end model: read port and commit latency
  initial forever begin
    @(posedge clk);
    if (bmem.exists(int'(rd_addr))) rd_data <= bmem[int'(rd_addr)];
    else rd_data <= pat(int'(rd_addr));
  end

  initial forever begin
    @(negedge clk);
    if (commit_req) begin
      tick(LAT);
      commit_done = 1'b1;
      ncommit++;
      tick(1);
      commit_done = 1'b0;
    end
  end

  // scoreboard monitor for the write port (R4)
  initial forever begin
    @(negedge clk);
    if (!rst && wr_en) begin
      bmem[int'(wr_addr)] = wr_data;
      if (exp_q.size() == 0) begin
        check("R4 unexpected write", {9'd0, wr_addr, wr_data}, 32'hFFFFFFFF);
      end else begin
        logic [22:0] e;
        e = exp_q.pop_front();
        check("R4 write addr/data", {9'd0, wr_addr, wr_data}, {9'd0, e});
      end
    end
  end

  // R11 monitor: drive must not change while SCL stays high
  initial begin
    logic ps, po;
    ps = 1'b1; po = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst && scl && ps && (sda_oe != po)) viol++;
      ps = scl; po = sda_oe;
    end
  end

  task automatic i2c_start();
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(2*Q);
    sda_m = 1'b0; tick(2*Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(Q);
    scl = 1'b1;   tick(2*Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl = 1'b1;   tick(2*Q);
      scl = 1'b0;   tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    ack = ~sda_line;
    tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl = 1'b1; tick(Q);
      b[i] = sda_line;
      tick(Q);
      scl = 1'b0;
    end
    tick(Q);
    sda_m = ~ack; tick(Q);
    scl = 1'b1;   tick(2*Q);
    scl = 1'b0;   tick(Q);
    sda_m = 1'b1;
  endtask

  // write transaction; driver pushes expected commit items into the queue
  task automatic do_write(input logic [7:0] hi, input logic [7:0] lo, input int n);
    logic ack;
    logic [7:0] sh [64];
    bit v [64];
    logic [5:0] off;
    int base;
    for (int k = 0; k < 64; k++) v[k] = 1'b0;
    off = lo[5:0];
    base = int'({hi[6:0], lo}) & 32'h7FC0;
    i2c_start();
    send_byte(8'hAA, ack); check("R1 select ack", 32'(ack), 1);
    send_byte(hi, ack);    check("R2 addr hi ack", 32'(ack), 1);
    send_byte(lo, ack);    check("R2 addr lo ack", 32'(ack), 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wdat[i], ack);
      if (wp) check("R6 data nack under wp", 32'(ack), 0);
      else begin
        check("R3 data ack", 32'(ack), 1);
        sh[off] = wdat[i]; v[off] = 1'b1; off = off + 6'd1;
      end
    end
    for (int k = 0; k < 64; k++) if (v[k]) begin
      exp_q.push_back({15'(base + k), sh[k]});
      refm[base + k] = sh[k];
    end
    i2c_stop();
  endtask

  task automatic poll_ready(output int tries);
    logic ack;
    tries = 0;
    for (int k = 0; k < 40; k++) begin
      i2c_start();
      send_byte(8'hAA, ack);
      tries++;
      if (ack) break;
      i2c_stop();
    end
  endtask

  task automatic read_seq(input int start_a, input int n, input string tag);
    logic [7:0] b;
    logic ack;
    send_byte(8'hAB, ack); check({tag, " read select ack"}, 32'(ack), 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      check(tag, 32'(b), 32'(ref_b((start_a + i) & 32'h7FFF)));
    end
    i2c_stop();
  endtask

  task automatic rand_read(input logic [7:0] hi, input logic [7:0] lo, input int n, input string tag);
    logic ack;
    i2c_start();
    send_byte(8'hAA, ack);
    send_byte(hi, ack);
    send_byte(lo, ack);
    i2c_start();
    read_seq(int'({hi[6:0], lo}), n, tag);
  endtask

  logic done_flag = 1'b0;

  initial begin
    logic ack;
    int tries, nc0;
    tick(5);
    rst = 1'b0;
    tick(2);
    check("R12 sda released after reset", 32'(sda_oe), 0);
    check("R12 no write after reset", 32'(wr_en), 0);
    check("R12 no commit after reset", 32'(commit_req), 0);

    // R1 mismatching strap and type code
    i2c_start(); send_byte(8'hA6, ack); i2c_stop();
    check("R1 strap mismatch nack", 32'(ack), 0);
    i2c_start(); send_byte(8'hBA, ack); i2c_stop();
    check("R1 type code mismatch nack", 32'(ack), 0);
    strap = 3'b010;
    i2c_start(); send_byte(8'hA4, ack); i2c_stop();
    check("R1 other strap value ack", 32'(ack), 1);
    strap = 3'b101;

    // R2/R3/R4 write with page wrap; top address bit set
    for (int i = 0; i < 6; i++) wdat[i] = 8'(8'h11 * (i + 1));
    do_write(8'h92, 8'h3C, 6);
    i2c_start(); send_byte(8'hAA, ack); i2c_stop();
    check("R5 select nack during commit", 32'(ack), 0);
    poll_ready(tries);
    check("R5 select ack after commit", 32'(tries < 40), 1);
    check("R4 one commit done", 32'(ncommit), 1);
    check("R4 all writes seen", 32'(exp_q.size()), 0);
    i2c_stop();

    rand_read(8'h12, 8'h00, 2, "R7 R3 wrapped bytes");
    rand_read(8'h12, 8'h3C, 4, "R8 R2 sequential read");
    i2c_start(); read_seq(32'h1240, 1, "R9 current address read");

    // R3 overwrite after a full wrap (65 bytes)
    for (int i = 0; i < 65; i++) wdat[i] = 8'(i * 3 + 1);
    do_write(8'h00, 8'h10, 65);
    poll_ready(tries); i2c_stop();
    check("R4 second commit", 32'(ncommit), 2);
    check("R4 full page written", 32'(exp_q.size()), 0);
    rand_read(8'h00, 8'h0F, 2, "R3 overwrite at wrapped offset");

    // R6 write protect
    nc0 = ncommit;
    wp = 1'b1;
    wdat[0] = 8'h55;
    do_write(8'h00, 8'h20, 1);
    tick(2*LAT);
    check("R6 no commit under wp", 32'(commit_req), 0);
    check("R6 commit count unchanged", 32'(ncommit), 32'(nc0));
    wp = 1'b0;
    rand_read(8'h00, 8'h20, 1, "R6 protected byte unchanged");

    // R8 rollover, R10 end on nack
    rand_read(8'h7F, 8'hFF, 2, "R8 rollover read");
    tick(10);
    check("R10 sda released after nack", 32'(sda_oe), 0);
    i2c_start(); read_seq(1, 1, "R10 R9 next read after nack");

    check("R11 no drive change with scl high", 32'(viol), 0);
    done_flag = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule